// File: doc/BRIEF.md
# 1-Wire Device Select Sequencer

This block runs the addressing phase that comes before any function command on a 1-Wire bus. A request starts the sequence. The block first commands a bus reset through a slot engine and checks the presence answer. It then addresses the target device in one of three ways. If exactly one device is known, it sends the skip-ROM command. If any other number of devices is known, it sends the match-ROM command followed by the 64-bit ROM ID. A resume request sends the resume command instead, which re-addresses the device that was matched last.

The block reports the outcome with a single done pulse and an error flag. The flag is low on success and high when no device answered the reset. The bus timing is left to the slot engine. This block only hands the engine one reset or one byte-write command at a time, and it waits for the engine's completion before it hands over the next one.

Top module: `ow_select_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `eng_reset_go` and `eng_byte_go` are all 0. No engine command is issued while `busy` is 0.
- R2: Each accepted request issues exactly one `eng_reset_go` pulse. It appears in the first cycle that `busy` is high and comes before any byte command.
- R3: If the reset completes with `eng_presence` = 0, no byte is sent. The sequence ends with `done` = 1 and `err` = 1 in the same cycle.
- R4: A select request (`req_resume` = 0) with `slave_count` = 1 sends exactly one byte, 0xCC, and ends with `err` = 0.
- R5: A select request with `slave_count` other than 1 sends exactly nine bytes: 0x55, then the ROM ID from bits [7:0] up to bits [63:56]. It ends with `err` = 0.
- R6: A resume request (`req_resume` = 1) sends exactly one byte, 0xA5, whatever the value of `slave_count`. It ends with `err` = 0.
- R7: `rom_id`, `slave_count` and `req_resume` are captured in the cycle the request is accepted. Later changes to them do not affect the bytes sent.
- R8: At most one engine command is outstanding at a time. After a reset or byte command, no further command is issued until `eng_done` has been seen.
- R9: `done` is high for exactly one cycle per accepted request. `busy` stays high from the cycle after acceptance up to and including the `done` cycle, and is low in the cycle after it.
- R10: A `req_valid` pulse seen while `busy` is high is ignored. It produces no second sequence and no extra `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request; accepted only while `busy` is low |
| req_resume | input | 1 | 1: resume addressing, 0: skip-ROM or match-ROM addressing |
| slave_count | input | CNT_W | Number of devices known on the bus |
| rom_id | input | 8*ROM_BYTES | ROM ID of the target device; byte 0 is sent first |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Valid with `done`: 1 when no presence was seen |
| eng_reset_go | output | 1 | One-cycle command to the slot engine: run a bus reset |
| eng_byte_go | output | 1 | One-cycle command to the slot engine: write `eng_byte` |
| eng_byte | output | 8 | Byte to be written, valid with `eng_byte_go` |
| eng_done | input | 1 | One-cycle completion pulse from the slot engine |
| eng_presence | input | 1 | Presence result, valid with `eng_done` after a reset |

## Verification
The hardest cases to reach are the ones that depend on time. One is a request that arrives in the middle of a sequence. Another is input data that changes after the request has been accepted but before the bytes that use it are sent. The bench reaches both in every vector. In the cycle after acceptance, it pulses `req_valid` again with the opposite request type and replaces `rom_id` with its complement. The sent byte log must still match the captured request.

A behavioural slot engine answers each command after a latency taken from a sweep that includes the shortest possible answer. This exercises the handshake where a completion arrives in the cycle right after the command. The sweep also covers both presence outcomes and the slave counts 0, 1, 2 and the maximum.

// File: rtl/ow_sel_pkg.sv
package ow_sel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RST_GO    = 3'd1,
    ST_RST_WAIT  = 3'd2,
    ST_BYTE_GO   = 3'd3,
    ST_BYTE_WAIT = 3'd4,
    ST_FINISH    = 3'd5
  } sel_state_t;

  // number of bytes in the addressing frame that follows the reset
  function automatic int unsigned frame_len(input logic resume, input logic single,
                                            input int unsigned rom_bytes);
    if (resume || single) return 1;
    return rom_bytes + 1;
  endfunction

  // command byte that opens the frame
  function automatic logic [7:0] frame_cmd(input logic resume, input logic single,
                                           input logic [7:0] c_skip, input logic [7:0] c_match,
                                           input logic [7:0] c_resume);
    if (resume) return c_resume;
    if (single) return c_skip;
    return c_match;
  endfunction

endpackage

// File: rtl/ow_sel_frame.sv
module ow_sel_frame
  import ow_sel_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned ROM_BYTES = 8,
  parameter logic [7:0]  CMD_SKIP  = 8'hCC,
  parameter logic [7:0]  CMD_MATCH = 8'h55,
  parameter logic [7:0]  CMD_RESUME = 8'hA5,
  localparam int unsigned ROM_W    = 8 * ROM_BYTES,
  localparam int unsigned IDX_W    = $clog2(ROM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             resume_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic [ROM_W-1:0] rom_in,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       cur_byte,
  output logic             last_byte
);

  logic             resume_q;
  logic             single_q;
  logic [ROM_W-1:0] rom_q;
  logic [7:0]       rom_b [ROM_BYTES];
  logic [7:0]       cmd_byte;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_q <= 1'b0;
      single_q <= 1'b0;
      rom_q    <= '0;
    end else if (capture) begin
      resume_q <= resume_in;
      single_q <= (count_in == CNT_W'(1));
      rom_q    <= rom_in;
    end
  end

  for (genvar g = 0; g < ROM_BYTES; g++) begin : g_split
    assign rom_b[g] = rom_q[8*g +: 8];
  end

  assign cmd_byte  = frame_cmd(resume_q, single_q, CMD_SKIP, CMD_MATCH, CMD_RESUME);
  assign last_idx  = IDX_W'(frame_len(resume_q, single_q, ROM_BYTES) - 1);
  assign last_byte = (idx == last_idx);

  always_comb begin
    cur_byte = cmd_byte;
    for (int k = 1; k <= ROM_BYTES; k++) begin
      if (idx == IDX_W'(k)) cur_byte = rom_b[k-1];
    end
  end

endmodule

// File: rtl/ow_sel_ctrl.sv
module ow_sel_ctrl
  import ow_sel_pkg::*;
#(
  parameter int unsigned ROM_BYTES = 8,
  localparam int unsigned IDX_W    = $clog2(ROM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             eng_done,
  input  logic             eng_presence,
  input  logic             last_byte,
  output logic             capture,
  output logic [IDX_W-1:0] idx,
  output logic             reset_go,
  output logic             byte_go,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             rst_wait,
  output logic             byte_wait
);

  sel_state_t state_q, state_d;
  logic [IDX_W-1:0] idx_d;
  logic             err_q, err_d;
  logic             pres_fail;
  logic             byte_ack;

  assign capture   = req_valid && (state_q == ST_IDLE);
  assign rst_wait  = (state_q == ST_RST_WAIT);
  assign byte_wait = (state_q == ST_BYTE_WAIT);
  assign pres_fail = rst_wait && eng_done && !eng_presence;
  assign byte_ack  = byte_wait && eng_done;

  always_comb begin
    state_d = state_q;
    idx_d   = idx;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (capture) begin
        state_d = ST_RST_GO;
        idx_d   = '0;
        err_d   = 1'b0;
      end
      ST_RST_GO:   state_d = ST_RST_WAIT;
      ST_RST_WAIT: if (eng_done) begin
        if (pres_fail) begin
          err_d   = 1'b1;
          state_d = ST_FINISH;
        end else begin
          state_d = ST_BYTE_GO;
        end
      end
      ST_BYTE_GO:   state_d = ST_BYTE_WAIT;
      ST_BYTE_WAIT: if (byte_ack) begin
        if (last_byte) begin
          state_d = ST_FINISH;
        end else begin
          idx_d   = idx + IDX_W'(1);
          state_d = ST_BYTE_GO;
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx     <= idx_d;
      err_q   <= err_d;
    end
  end

  assign reset_go = (state_q == ST_RST_GO);
  assign byte_go  = (state_q == ST_BYTE_GO);
  assign busy     = (state_q != ST_IDLE);
  assign done     = (state_q == ST_FINISH);
  assign err      = done && err_q;

endmodule

// File: rtl/ow_select_seq.sv
module ow_select_seq
  import ow_sel_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned ROM_BYTES  = 8,
  parameter logic [7:0]  CMD_SKIP   = 8'hCC,
  parameter logic [7:0]  CMD_MATCH  = 8'h55,
  parameter logic [7:0]  CMD_RESUME = 8'hA5,
  localparam int unsigned ROM_W     = 8 * ROM_BYTES,
  localparam int unsigned IDX_W     = $clog2(ROM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_resume,
  input  logic [CNT_W-1:0] slave_count,
  input  logic [ROM_W-1:0] rom_id,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             eng_reset_go,
  output logic             eng_byte_go,
  output logic [7:0]       eng_byte,
  input  logic             eng_done,
  input  logic             eng_presence
);

  logic             capture;
  logic [IDX_W-1:0] idx;
  logic             last_byte;
  logic             rst_wait;
  logic             byte_wait;

  ow_sel_ctrl #(.ROM_BYTES(ROM_BYTES)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .eng_done     (eng_done),
    .eng_presence (eng_presence),
    .last_byte    (last_byte),
    .capture      (capture),
    .idx          (idx),
    .reset_go     (eng_reset_go),
    .byte_go      (eng_byte_go),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .rst_wait     (rst_wait),
    .byte_wait    (byte_wait)
  );

  ow_sel_frame #(
    .CNT_W      (CNT_W),
    .ROM_BYTES  (ROM_BYTES),
    .CMD_SKIP   (CMD_SKIP),
    .CMD_MATCH  (CMD_MATCH),
    .CMD_RESUME (CMD_RESUME)
  ) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .resume_in (req_resume),
    .count_in  (slave_count),
    .rom_in    (rom_id),
    .idx       (idx),
    .cur_byte  (eng_byte),
    .last_byte (last_byte)
  );

endmodule

// File: rtl/ow_select_seq_chk.sv
module ow_select_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic eng_reset_go,
  input logic eng_byte_go,
  input logic eng_done,
  input logic eng_presence,
  input logic rst_wait,
  input logic byte_wait
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(eng_reset_go || eng_byte_go)); // R1
  AST_RESET_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eng_reset_go); // R2
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({eng_reset_go, eng_byte_go}) <= 1); // R8
  AST_BYTE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_byte_go |=> !eng_byte_go); // R8
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wait || rst_wait) && !eng_done |=> !(eng_byte_go || eng_reset_go)); // R8
  AST_NO_PRES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wait && eng_done && !eng_presence |=> done && err && !eng_byte_go); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done && busy); // R9

endmodule

bind ow_select_seq ow_select_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .eng_reset_go (eng_reset_go),
  .eng_byte_go  (eng_byte_go),
  .eng_done     (eng_done),
  .eng_presence (eng_presence),
  .rst_wait     (rst_wait),
  .byte_wait    (byte_wait)
);

// File: tb/test_ow_select_seq.sv
`timescale 1ns/1ps
module test_ow_select_seq;

  localparam int CNT_W = 8;
  localparam int ROM_BYTES = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_resume = 1'b0;
  logic [7:0]  slave_count = '0;
  logic [63:0] rom_id = '0;
  logic        busy, done, err, eng_reset_go, eng_byte_go;
  logic [7:0]  eng_byte;
  logic        eng_done = 1'b0;
  logic        eng_presence = 1'b0;

  always #10 clk = ~clk;

  ow_select_seq i_ow_select_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_resume(req_resume),
    .slave_count(slave_count), .rom_id(rom_id), .busy(busy), .done(done), .err(err),
    .eng_reset_go(eng_reset_go), .eng_byte_go(eng_byte_go), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_presence(eng_presence)
  );

  int n_checks = 0;
  int n_fail = 0;

  // behavioural slot engine
  int       eng_lat = 0;
  logic     eng_pres_cfg = 1'b1;
  int       eng_cnt = 0;
  logic     eng_pending = 1'b0;
  int       n_resets = 0;
  int       n_bytes = 0;
  int       overlap = 0;
  int       byte_before_reset = 0;
  logic [7:0] log_b [16];

  always @(negedge clk) begin
    eng_done = 1'b0;
    if (eng_pending) begin
      eng_cnt = eng_cnt - 1;
      if (eng_cnt == 0) begin
        eng_done = 1'b1;
        eng_pending = 1'b0;
      end
    end
    if (eng_reset_go || eng_byte_go) begin
      if (eng_pending) overlap++;
      eng_pending = 1'b1;
      eng_cnt = eng_lat + 1;
      if (eng_reset_go) n_resets++;
      if (eng_byte_go) begin
        if (n_resets == 0) byte_before_reset++;
        if (n_bytes < 16) log_b[n_bytes] = eng_byte;
        n_bytes++;
      end
    end
    eng_presence = eng_pres_cfg;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic resume, input logic [7:0] cnt, input logic pres,
                         input int lat, input logic [63:0] rom);
    int waited;
    int exp_len;
    logic [7:0] exp_b [16];
    eng_lat = lat;
    eng_pres_cfg = pres;
    n_resets = 0; n_bytes = 0; overlap = 0; byte_before_reset = 0;
    @(negedge clk);
    req_valid = 1'b1; req_resume = resume; slave_count = cnt; rom_id = rom;
    @(negedge clk);
    // R10/R7: stray request and changed inputs while busy
    req_resume = ~resume; slave_count = (cnt == 8'd1) ? 8'd3 : 8'd1; rom_id = ~rom;
    check("R9", "busy after accept", busy, 1);
    check("R2", "reset go first cycle", eng_reset_go, 1);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 2000) begin
      if (!busy) begin
        check("R9", "busy dropped early", busy, 1);
        waited = 2000;
      end else begin
        @(negedge clk);
        waited++;
      end
    end
    check("R9", "done seen", done, 1);
    // expected frame
    if (!pres) exp_len = 0;
    else if (resume) begin exp_len = 1; exp_b[0] = 8'hA5; end
    else if (cnt == 8'd1) begin exp_len = 1; exp_b[0] = 8'hCC; end
    else begin
      exp_len = 9; exp_b[0] = 8'h55;
      for (int k = 0; k < 8; k++) exp_b[k+1] = 8'((rom >> (8*k)) & 64'hFF);
    end
    check(pres ? "R4" : "R3", "err", err, pres ? 0 : 1);
    check("R2", "reset count", n_resets, 1);
    check("R2", "byte before reset", byte_before_reset, 0);
    check("R8", "overlapping commands", overlap, 0);
    check(resume ? "R6" : (cnt == 8'd1 ? "R4" : "R5"), "byte count", n_bytes, exp_len);
    if (n_bytes == exp_len)
      for (int k = 0; k < exp_len; k++)
        check(resume ? "R6" : (cnt == 8'd1 ? "R4" : "R7"), "byte value", log_b[k], exp_b[k]);
    @(negedge clk);
    check("R9", "done one cycle", done, 0);
    check("R9", "busy low after done", busy, 0);
    // R10: no second sequence started by the stray request
    repeat (3) @(negedge clk);
    check("R10", "no extra reset", n_resets, 1);
    check("R10", "no extra done", done, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] cnts [4];
    logic [63:0] roms [2];
    int lats [3];
    cnts[0] = 8'd0; cnts[1] = 8'd1; cnts[2] = 8'd2; cnts[3] = 8'd255;
    roms[0] = 64'h0123_4567_89AB_CDEF; roms[1] = 64'hF00D_5A5A_C33C_8001;
    lats[0] = 0; lats[1] = 1; lats[2] = 4;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "err", err, 0);
    check("R1", "reset go", eng_reset_go, 0);
    check("R1", "byte go", eng_byte_go, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after release", busy, 0);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 2; p++)
          for (int l = 0; l < 3; l++)
            for (int m = 0; m < 2; m++)
              run_vec(r[0], cnts[c], p[0], lats[l], roms[m]);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule